// File: doc/BRIEF.md
# Mailbox Command/Response Register Bridge

This block sits between a word-addressed host register bus and a mailbox responder. The host builds a command packet by writing words into a command FIFO. The register that receives each write decides where the packet ends: a write to the command data offset adds a word that is not the last one, and a write to the command last-word offset adds the closing word and flags it. A command with no arguments is a single word written to the last-word offset. Command words leave on a valid/ready stream whose `cmdLast` flag marks the packet boundary.

Responses come back on a second valid/ready stream that carries start-of-packet and end-of-packet flags, and they are kept in a response FIFO. The host polls the interrupt status offset or the response status offset. It then pops words through the response data offset. The status word packs the fill level together with the boundary flags of the head word. The free-space readback follows the true count of free command entries with a fixed lag of three cycles.

Top module: `mbox_bridge`

## Requirements
- R1: A register write to offset 0 appends `regWriteData` to the command FIFO with its last flag at 0, and a write to offset 1 appends it with the last flag at 1. Words leave on `cmdData`/`cmdLast` in the order they were written.
- R2: A write to offset 0 or 1 while the command FIFO holds 16 words is discarded, even if a stream pop happens in the same cycle. The FIFO contents and the stream output are unchanged by it.
- R3: A read of offset 2 returns the free command entries, zero-extended from 5 bits. The value lags the true count: a read sampled on the third clock edge after the edge that changed the count returns the new value, while reads on the first and second edges return the old one. After reset the value is 16.
- R4: `cmdValid` is high exactly while the command FIFO is not empty. A word is removed on each edge where `cmdValid` and `cmdReady` are both high.
- R5: `rspReady` is high exactly while the response FIFO holds fewer than 16 words. A word with its SOP and EOP flags is stored on each edge where `rspValid` and `rspReady` are both high.
- R6: A read of offset 5 pops the head response word and returns its data. If the response FIFO is empty, the read returns 0 and removes nothing.
- R7: A read of offset 6 returns the response status: bit 0 is the head word's SOP, bit 1 is its EOP, bits 6:2 are the fill level, and all upper bits are 0. The flags read 0 when the FIFO is empty. For example, 11 words with SOP only on the head read 0x2D, and one single-word packet reads 0x07.
- R8: A read of offset 8 returns bit 0 = 1 while the response FIFO holds at least one word, and 0 otherwise. All other bits are 0.
- R9: Every read raises `regReadValid` for exactly one cycle, on the cycle after the read, with `regReadData` valid in that cycle. Offsets other than 2, 5, 6 and 8 read as 0. Writes to offsets other than 0 and 1 change nothing.
- R10: After reset, `cmdValid` is 0, `rspReady` is 1 and `regReadValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word offset |
| regWrite | input | 1 | Register write strobe |
| regWriteData | input | 32 | Register write data |
| regRead | input | 1 | Register read strobe |
| regReadData | output | 32 | Read data, valid with regReadValid |
| regReadValid | output | 1 | One-cycle pulse after each read |
| cmdValid | output | 1 | Command stream word available |
| cmdReady | input | 1 | Command stream sink accepts word |
| cmdData | output | 32 | Command stream word |
| cmdLast | output | 1 | Command word closes its packet |
| rspValid | input | 1 | Response stream word offered |
| rspReady | output | 1 | Response FIFO has room |
| rspData | input | 32 | Response stream word |
| rspSop | input | 1 | Response word opens a packet |
| rspEop | input | 1 | Response word closes a packet |

## Verification
The bench first runs directed packets. A three-word command whose packet boundary is set by the final write address separates the two push offsets. Overfilling the command FIFO with the sink stalled exposes any write that is accepted when it should be discarded. Back-to-back free-space reads right after a write pin down the exact lag cycle. A single-word response and an eleven-word response give the two status encodings. Reads on an empty response FIFO show that no pop happens, and a seventeenth offered response word shows the backpressure. A long random phase then mixes writes, reads, unmapped offsets, sink stalls and response packets of random length. A cycle-level bench model follows every FIFO, including simultaneous push and pop at full and empty, and checks each output and every read result against it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [3:0] OFF_CMD      = 4'd0;
  localparam logic [3:0] OFF_CMD_LAST = 4'd1;
  localparam logic [3:0] OFF_FREE     = 4'd2;
  localparam logic [3:0] OFF_RSP_DATA = 4'd5;
  localparam logic [3:0] OFF_RSP_STAT = 4'd6;
  localparam logic [3:0] OFF_IRQ      = 4'd8;

  // strobes from register control to datapath
  typedef struct packed {
    logic cmdWrite;   // write hit a command push offset
    logic cmdLast;    // the push closes its packet
    logic rspPop;     // pop the response head (already gated by empty)
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             din,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_full_refuses_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (full && $stable(wrPtr)));
  assert_empty_refuses_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> (empty && $stable(rdPtr)));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrite,
  input  logic                regRead,
  input  logic [CNT_W-1:0]    freeLagged,
  input  logic [DATA_W-1:0]   rspHeadData,
  input  logic                rspHeadSop,
  input  logic                rspHeadEop,
  input  logic [CNT_W-1:0]    rspCount,
  input  logic                rspEmpty,
  output mbox_strobe_t        strobe,
  output logic [DATA_W-1:0]   regReadData,
  output logic                regReadValid
);
  localparam int PAD_STAT = DATA_W - CNT_W - 2;

  logic [DATA_W-1:0] readNext;
  logic hitCmd, hitLast;

  assign hitCmd  = (regAddr == ADDR_W'(OFF_CMD));
  assign hitLast = (regAddr == ADDR_W'(OFF_CMD_LAST));

  always_comb begin
    strobe.cmdWrite = regWrite && (hitCmd || hitLast);
    strobe.cmdLast  = hitLast;
    strobe.rspPop   = regRead && (regAddr == ADDR_W'(OFF_RSP_DATA)) && !rspEmpty;
  end

  always_comb begin
    readNext = '0;
    case (regAddr)
      ADDR_W'(OFF_FREE):     readNext = DATA_W'(freeLagged);
      ADDR_W'(OFF_RSP_DATA): readNext = rspEmpty ? '0 : rspHeadData;
      ADDR_W'(OFF_RSP_STAT): readNext = {{PAD_STAT{1'b0}}, rspCount,
                                         rspHeadEop && !rspEmpty,
                                         rspHeadSop && !rspEmpty};
      ADDR_W'(OFF_IRQ):      readNext = DATA_W'(!rspEmpty);
      default:               readNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regReadData  <= '0;
      regReadValid <= 1'b0;
    end else begin
      regReadValid <= regRead;
      if (regRead) regReadData <= readNext;
    end
  end

  assert_read_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    regRead |=> regReadValid);
  assert_read_valid_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regRead |=> !regReadValid);
  assert_empty_data_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_W'(OFF_RSP_DATA) && rspEmpty) |=> (regReadData == '0));
  assert_irq_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr == ADDR_W'(OFF_IRQ)) |=> (regReadData[0] == $past(rspCount != '0)));
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int FREE_LAG = 3,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  mbox_strobe_t        strobe,
  input  logic [DATA_W-1:0]   regWriteData,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [DATA_W-1:0]   cmdData,
  output logic                cmdLast,
  input  logic                rspValid,
  output logic                rspReady,
  input  logic [DATA_W-1:0]   rspData,
  input  logic                rspSop,
  input  logic                rspEop,
  output logic [CNT_W-1:0]    freeLagged,
  output logic [DATA_W-1:0]   rspHeadData,
  output logic                rspHeadSop,
  output logic                rspHeadEop,
  output logic [CNT_W-1:0]    rspCount,
  output logic                rspEmpty
);
  localparam int LAG_CNT_W = $clog2(FREE_LAG + 1);

  logic [CNT_W-1:0] cmdCount;
  logic cmdFull, cmdEmpty, cmdPush, cmdPop;
  logic rspFull, rspPush;
  logic [CNT_W-1:0] trueFree, nextFree, nextCount;
  logic [CNT_W-1:0] freeLag [FREE_LAG];

  assign cmdPush = strobe.cmdWrite && !cmdFull;
  assign cmdPop  = cmdValid && cmdReady;
  assign cmdValid = !cmdEmpty;

  mbox_fifo #(.WIDTH(DATA_W + 1), .DEPTH(DEPTH)) i_cmdFifo (
    .clk(clk), .rstN(rstN), .push(cmdPush), .pop(cmdPop),
    .din({strobe.cmdLast, regWriteData}), .dout({cmdLast, cmdData}),
    .count(cmdCount), .full(cmdFull), .empty(cmdEmpty));

  assign rspReady = !rspFull;
  assign rspPush  = rspValid && rspReady;

  mbox_fifo #(.WIDTH(DATA_W + 2), .DEPTH(DEPTH)) i_rspFifo (
    .clk(clk), .rstN(rstN), .push(rspPush), .pop(strobe.rspPop),
    .din({rspSop, rspEop, rspData}), .dout({rspHeadSop, rspHeadEop, rspHeadData}),
    .count(rspCount), .full(rspFull), .empty(rspEmpty));

  // free-space lag line, first stage loaded with the count after this edge
  assign trueFree  = CNT_W'(DEPTH) - cmdCount;
  assign nextCount = cmdCount + CNT_W'(cmdPush) - CNT_W'(cmdPop);
  assign nextFree  = CNT_W'(DEPTH) - nextCount;

  always_ff @(posedge clk) begin
    if (!rstN) freeLag[0] <= CNT_W'(DEPTH);
    else       freeLag[0] <= nextFree;
  end

  for (genvar s = 1; s < FREE_LAG; s++) begin : g_lag
    always_ff @(posedge clk) begin
      if (!rstN) freeLag[s] <= CNT_W'(DEPTH);
      else       freeLag[s] <= freeLag[s-1];
    end
  end

  assign freeLagged = freeLag[FREE_LAG-1];

  // checker: once the count has been steady long enough, the readback agrees
  logic [LAG_CNT_W-1:0] steadyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) steadyCnt <= '0;
    else if (cmdPush || cmdPop) steadyCnt <= '0;
    else if (steadyCnt != LAG_CNT_W'(FREE_LAG)) steadyCnt <= steadyCnt + 1'b1;
  end

  assert_free_settles_R3: assert property (@(posedge clk) disable iff (!rstN)
    (steadyCnt == LAG_CNT_W'(FREE_LAG)) |-> (freeLagged == trueFree));
  assert_discard_when_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFull && strobe.cmdWrite && !cmdReady) |=> (cmdFull && $stable(cmdData)));
  assert_cmd_valid_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData) && $stable(cmdLast)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!rspReady && !strobe.rspPop) |=> (!rspReady && $stable(rspCount)));
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int DEPTH    = 16,
  parameter int FREE_LAG = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrite,
  input  logic [DATA_W-1:0]   regWriteData,
  input  logic                regRead,
  output logic [DATA_W-1:0]   regReadData,
  output logic                regReadValid,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [DATA_W-1:0]   cmdData,
  output logic                cmdLast,
  input  logic                rspValid,
  output logic                rspReady,
  input  logic [DATA_W-1:0]   rspData,
  input  logic                rspSop,
  input  logic                rspEop
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mbox_strobe_t strobe;
  logic [CNT_W-1:0] freeLagged, rspCount;
  logic [DATA_W-1:0] rspHeadData;
  logic rspHeadSop, rspHeadEop, rspEmpty;

  mbox_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite), .regRead(regRead),
    .freeLagged(freeLagged), .rspHeadData(rspHeadData), .rspHeadSop(rspHeadSop),
    .rspHeadEop(rspHeadEop), .rspCount(rspCount), .rspEmpty(rspEmpty),
    .strobe(strobe), .regReadData(regReadData), .regReadValid(regReadValid));

  mbox_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FREE_LAG(FREE_LAG), .CNT_W(CNT_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWriteData(regWriteData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData), .cmdLast(cmdLast),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspSop(rspSop),
    .rspEop(rspEop), .freeLagged(freeLagged), .rspHeadData(rspHeadData),
    .rspHeadSop(rspHeadSop), .rspHeadEop(rspHeadEop), .rspCount(rspCount),
    .rspEmpty(rspEmpty));
endmodule

// File: tb/test_mbox_bridge.sv
module test_mbox_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrite = 1'b0, regRead = 1'b0;
  logic [31:0] regWriteData = '0;
  logic [31:0] regReadData;
  logic regReadValid;
  logic cmdValid, cmdLast, rspReady;
  logic cmdReady = 1'b0;
  logic [31:0] cmdData;
  logic rspValid = 1'b0, rspSop = 1'b0, rspEop = 1'b0;
  logic [31:0] rspData = '0;

  mbox_bridge i_mbox_bridge (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWriteData(regWriteData), .regRead(regRead), .regReadData(regReadData),
    .regReadValid(regReadValid), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .cmdLast(cmdLast), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspSop(rspSop), .rspEop(rspEop));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench model
  logic [32:0] cmdQ [$];
  logic [33:0] rspQ [$];
  int lag [3] = '{DEPTH, DEPTH, DEPTH};
  bit pendRead = 1'b0, rspTaken = 1'b0;
  logic [31:0] pendExp = '0;
  logic [3:0] pendAddr = '0;
  int genLen = 0, genPos = 0;
  logic [31:0] genWord = 32'h5000_0000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic string readTag(input logic [3:0] a);
    case (a)
      4'd2: return "R3 free readback";
      4'd5: return "R6 response data";
      4'd6: return "R7 response status";
      4'd8: return "R8 interrupt status";
      default: return "R9 unmapped read";
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      4'd2: v = 32'(lag[2]);
      4'd5: if (rspQ.size() > 0) v = rspQ[0][31:0];
      4'd6: begin
        v = 32'(rspQ.size()) << 2;
        if (rspQ.size() > 0) v = v | {30'd0, rspQ[0][32], rspQ[0][33]};
      end
      4'd8: v = {31'd0, rspQ.size() > 0};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step();
    bit cPush, cPop, rPush, rPop;
    @(posedge clk);
    cPop  = cmdReady && cmdQ.size() > 0;
    cPush = regWrite && (regAddr == 4'd0 || regAddr == 4'd1) && cmdQ.size() < DEPTH;
    rPush = rspValid && rspQ.size() < DEPTH;
    rPop  = regRead && regAddr == 4'd5 && rspQ.size() > 0;
    pendRead = regRead;
    if (regRead) begin
      pendExp  = expRead(regAddr);
      pendAddr = regAddr;
    end
    if (cPop) void'(cmdQ.pop_front());
    if (cPush) cmdQ.push_back({regAddr == 4'd1, regWriteData});
    if (rPop) void'(rspQ.pop_front());
    if (rPush) rspQ.push_back({rspSop, rspEop, rspData});
    lag[2] = lag[1];
    lag[1] = lag[0];
    lag[0] = DEPTH - cmdQ.size();
    rspTaken = rPush;
    @(negedge clk);
    chk(cmdValid == (cmdQ.size() > 0), "R4 cmdValid", {31'd0, cmdValid}, {31'd0, cmdQ.size() > 0});
    if (cmdValid && cmdQ.size() > 0)
      chk({cmdLast, cmdData} == cmdQ[0], "R1 command word/last",
          cmdData ^ {cmdLast, 31'd0}, cmdQ[0][31:0] ^ {cmdQ[0][32], 31'd0});
    chk(rspReady == (rspQ.size() < DEPTH), "R5 rspReady", {31'd0, rspReady}, {31'd0, rspQ.size() < DEPTH});
    chk(regReadValid == pendRead, "R9 readValid", {31'd0, regReadValid}, {31'd0, pendRead});
    if (pendRead) chk(regReadData == pendExp, readTag(pendAddr), regReadData, pendExp);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    regWrite = 1'b1; regAddr = a; regWriteData = d;
    step();
    regWrite = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [31:0] d);
    regRead = 1'b1; regAddr = a;
    step();
    regRead = 1'b0;
    d = regReadData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pushRsp(input logic [31:0] d, input bit s, input bit e);
    rspValid = 1'b1; rspData = d; rspSop = s; rspEop = e;
    do step(); while (!rspTaken);
    rspValid = 1'b0;
  endtask

  task automatic loadGen();
    if (genPos >= genLen) begin
      genLen = 1 + int'($urandom % 5);
      genPos = 0;
    end
    genWord = genWord + 32'h0001_0003;
    rspData = genWord;
    rspSop = (genPos == 0);
    rspEop = (genPos == genLen - 1);
    genPos++;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h2468ACE1));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cmdValid == 1'b0, "R10 reset cmdValid", {31'd0, cmdValid}, 32'd0);
    chk(rspReady == 1'b1, "R10 reset rspReady", {31'd0, rspReady}, 32'd1);
    chk(regReadValid == 1'b0, "R10 reset readValid", {31'd0, regReadValid}, 32'd0);
    rstN = 1'b1;

    doRead(4'd2, rd);
    chk(rd == 32'd16, "R3 free after reset", rd, 32'd16);

    // R1: three-word packet, boundary from the final address
    cmdReady = 1'b0;
    doWrite(4'd0, 32'hA000_0001);
    doWrite(4'd0, 32'hA000_0002);
    doWrite(4'd1, 32'hA000_0003);
    chk(cmdData == 32'hA000_0001 && !cmdLast, "R1 head word not last", cmdData, 32'hA000_0001);
    cmdReady = 1'b1;
    step();
    step();
    chk(cmdLast == 1'b1 && cmdData == 32'hA000_0003, "R1 final word flagged last", {cmdLast, cmdData[30:0]}, 32'hA000_0003 | 32'h8000_0000);
    step();
    chk(cmdValid == 1'b0, "R4 drained", {31'd0, cmdValid}, 32'd0);
    cmdReady = 1'b0;
    idle(4);

    // R3: exact lag of the free readback
    doWrite(4'd1, 32'hB000_0000);
    doRead(4'd2, rd); chk(rd == 32'd16, "R3 lag edge 1", rd, 32'd16);
    doRead(4'd2, rd); chk(rd == 32'd16, "R3 lag edge 2", rd, 32'd16);
    doRead(4'd2, rd); chk(rd == 32'd15, "R3 lag edge 3", rd, 32'd15);

    // R2: overfill with sink stalled
    for (int i = 0; i < 18; i++) doWrite(4'd0, 32'hC000_0000 + i);
    idle(4);
    doRead(4'd2, rd); chk(rd == 32'd0, "R2 free zero when full", rd, 32'd0);
    regWrite = 1'b1; regAddr = 4'd1; regWriteData = 32'hDEAD_0000; cmdReady = 1'b1;
    step();
    regWrite = 1'b0;
    idle(DEPTH + 2);
    chk(cmdValid == 1'b0, "R2 discarded words never emitted", {31'd0, cmdValid}, 32'd0);
    cmdReady = 1'b0;
    idle(4);

    // R6: empty pop returns zero, removes nothing
    doRead(4'd5, rd); chk(rd == 32'd0, "R6 empty read zero", rd, 32'd0);
    doRead(4'd6, rd); chk(rd == 32'd0, "R7 empty status", rd, 32'd0);
    doRead(4'd8, rd); chk(rd == 32'd0, "R8 irq clear when empty", rd, 32'd0);

    // R7: single-word packet
    pushRsp(32'h1111_0000, 1'b1, 1'b1);
    doRead(4'd6, rd); chk(rd == 32'h07, "R7 single-word status", rd, 32'h07);
    doRead(4'd5, rd); chk(rd == 32'h1111_0000, "R6 pop data", rd, 32'h1111_0000);

    // R7/R8: eleven-word packet
    for (int i = 0; i < 11; i++) pushRsp(32'h2222_0000 + i, i == 0, i == 10);
    doRead(4'd6, rd); chk(rd == 32'h2D, "R7 eleven-word status", rd, 32'h2D);
    doRead(4'd8, rd); chk(rd == 32'd1, "R8 irq set", rd, 32'd1);
    for (int i = 0; i < 10; i++) doRead(4'd5, rd);
    doRead(4'd6, rd); chk(rd == 32'h06, "R7 last word status", rd, 32'h06);
    doRead(4'd5, rd); chk(rd == 32'h2222_000A, "R6 last word data", rd, 32'h2222_000A);

    // R5: backpressure at 16
    for (int i = 0; i < DEPTH; i++) pushRsp(32'h3333_0000 + i, 1'b0, 1'b0);
    rspValid = 1'b1; rspData = 32'h3333_FFFF; rspSop = 1'b0; rspEop = 1'b1;
    step();
    chk(rspReady == 1'b0 && !rspTaken, "R5 ready low when full", {31'd0, rspReady}, 32'd0);
    doRead(4'd5, rd);
    if (!rspTaken) step();
    rspValid = 1'b0;
    doRead(4'd6, rd); chk(rd == 32'(DEPTH << 2), "R5 refilled to 16", rd, 32'(DEPTH << 2));
    for (int i = 0; i < DEPTH; i++) doRead(4'd5, rd);
    chk(rd == 32'h3333_FFFF, "R5 held word stored last", rd, 32'h3333_FFFF);

    // R9: unmapped offsets
    doWrite(4'd7, 32'hFFFF_FFFF);
    doWrite(4'd2, 32'hFFFF_FFFF);
    doRead(4'd3, rd); chk(rd == 32'd0, "R9 unmapped read zero", rd, 32'd0);
    chk(cmdValid == 1'b0, "R9 unmapped write ignored", {31'd0, cmdValid}, 32'd0);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int r;
      r = int'($urandom % 8);
      regWrite = 1'b0; regRead = 1'b0;
      if (r < 3) begin
        regWrite = 1'b1;
        case ($urandom % 6)
          0, 1, 2: regAddr = 4'd0;
          3, 4:    regAddr = 4'd1;
          default: regAddr = 4'(3 + ($urandom % 13));
        endcase
        regWriteData = $urandom;
      end else if (r < 6) begin
        regRead = 1'b1;
        case ($urandom % 8)
          0:       regAddr = 4'd2;
          1, 2, 3: regAddr = 4'd5;
          4, 5:    regAddr = 4'd6;
          6:       regAddr = 4'd8;
          default: regAddr = 4'($urandom);
        endcase
      end
      cmdReady = ((cyc / 500) % 2 == 0) ? ($urandom % 8 == 0) : ($urandom % 4 != 0);
      if (!rspValid || rspTaken) begin
        rspValid = ($urandom % 2 == 0);
        if (rspValid) loadGen();
      end
      step();
    end
    regWrite = 1'b0; regRead = 1'b0; rspValid = 1'b0;
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule